// File: doc/BRIEF.md
# PCI Interrupt Router and CPU Line Trigger

This block takes one interrupt report at a time from a PCI device. A report carries the device's device/function number, the interrupt pin it uses (INTA to INTD) and a valid strobe. The block turns the report into an internal interrupt number using a fixed per-slot board table. Slots on the expansion connectors rotate the pin number by the slot position. That internal number is the block's routing output.

When the number falls inside the block's internal line range, the block drives a single CPU interrupt output. Two configuration words hold one bit per internal line. The trigger-mode word selects between a one-cycle pulse and a held level. In level mode, the polarity word gives the level that is held.

The interrupt number is a combinational function of the current slot and pin. The CPU line is registered: it changes on the clock edge that samples the report. Enable masking, status capture and priority among several sources belong to other blocks.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `cpu_irq` is low.
- R2: The slot number is `devfn[7:3]`. The function bits `devfn[2:0]` have no effect on `irq_num` or on `cpu_irq`.
- R3: For slot 5, `irq_num` is 32 plus the pin index, where INTA=0, INTB=1, INTC=2 and INTD=3.
- R4: For slot 6, `irq_num` is 36 for every pin. For slot 7, it is 37 for every pin.
- R5: For slots 8 through 12 inclusive, `irq_num` = 38 + (slot − 8) + pin. Slot 12 with pin 3 gives 45.
- R6: For any other slot, `irq_num` equals the pin index. A report from such a slot leaves `cpu_irq` unchanged.
- R7: The internal line of a routed report is `irq_num` − 32, and it selects bit `irq_num − 32` of `edge_cfg` and of `pol_cfg`. If that `edge_cfg` bit is 1, `cpu_irq` is high for exactly the one cycle after the report's sampling edge. It then returns low, unless another pulse-mode report arrives.
- R8: If that `edge_cfg` bit is 0, `cpu_irq` takes the value of the selected `pol_cfg` bit after the sampling edge. It holds that value until the next routed report.
- R9: A pulse ends low even when the line was held high before it. A level-mode report that arrives in the cycle a pulse would end replaces the fall with its polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An interrupt report is present this cycle |
| devfn | input | 8 | Device/function number of the reporting device |
| pin | input | 2 | Interrupt pin index, INTA=0 through INTD=3 |
| edge_cfg | input | 32 | Per internal line: 1 = pulse, 0 = level |
| pol_cfg | input | 32 | Per internal line: level driven in level mode |
| irq_num | output | 8 | Routed interrupt number for the current slot and pin |
| cpu_irq | output | 1 | CPU interrupt line |

## Verification
The fall at the end of a pulse can coincide with a new routed report. A pulse-mode report in that cycle keeps the line high for another cycle. A level-mode report replaces the fall with its polarity bit. An unrouted report lets the fall happen. The bench provokes these cases with back-to-back directed reports and with dense random reports. Each sampled `cpu_irq` is judged against a bench model that holds the line level and a pending-fall flag.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   typedef logic [1:0] pin_idx_t;

   typedef enum logic {
      DRV_LEVEL = 1'b0,
      DRV_PULSE = 1'b1
   } drv_mode_e;
endpackage

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
   parameter int IRQ_W     = 8,
   parameter int IRQ_BASE  = 32,
   parameter int NUM_LINES = 32,
   parameter int SLOT_SB   = 5,
   parameter int SLOT_GFX  = 6,
   parameter int SLOT_NIC  = 7,
   parameter int GFX_LINE  = 4,
   parameter int NIC_LINE  = 5,
   parameter int SLOT_LO   = 8,
   parameter int SLOT_HI   = 12,
   parameter int EXP_LINE0 = 6,
   localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [4:0]           slot,
   input  pirq_pkg::pin_idx_t   pin,
   output logic [IRQ_W-1:0]     irq_num,
   output logic                 hit,
   output logic [LINE_W-1:0]    line
);
   int v;

   always_comb begin
      if (int'(slot) == SLOT_SB)
         v = IRQ_BASE + int'(pin);
      else if (int'(slot) == SLOT_GFX)
         v = IRQ_BASE + GFX_LINE;
      else if (int'(slot) == SLOT_NIC)
         v = IRQ_BASE + NIC_LINE;
      else if (int'(slot) >= SLOT_LO && int'(slot) <= SLOT_HI)
         v = IRQ_BASE + EXP_LINE0 + (int'(slot) - SLOT_LO) + int'(pin);
      else
         v = int'(pin);
   end

   assign irq_num = IRQ_W'(v);
   assign hit     = (v >= IRQ_BASE) && (v < IRQ_BASE + NUM_LINES);
   assign line    = LINE_W'(v - IRQ_BASE);
endmodule

// File: rtl/pirq_line_drive.sv
module pirq_line_drive #(
   parameter int NUM_LINES = 32,
   localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_valid,
   input  logic                 hit,
   input  logic [LINE_W-1:0]    line,
   input  logic [NUM_LINES-1:0] edge_cfg,
   input  logic [NUM_LINES-1:0] pol_cfg,
   output logic                 cpu_irq,
   output logic                 pulse_q
);
   import pirq_pkg::*;

   logic      line_ok;
   drv_mode_e mode;
   logic      pol_bit;

   generate
      if ((1 << LINE_W) == NUM_LINES) begin : g_pow2
         assign line_ok = 1'b1;
         assign mode    = drv_mode_e'(edge_cfg[line]);
         assign pol_bit = pol_cfg[line];
      end else begin : g_guard
         assign line_ok = int'(line) < NUM_LINES;
         assign mode    = line_ok ? drv_mode_e'(edge_cfg[line]) : DRV_LEVEL;
         assign pol_bit = line_ok ? pol_cfg[line] : 1'b0;
      end
   endgenerate

   logic take;
   assign take = ev_valid && hit && line_ok;

   logic q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q       <= 1'b0;
         pulse_q <= 1'b0;
      end else if (take) begin
         if (mode == DRV_PULSE) begin
            q       <= 1'b1;
            pulse_q <= 1'b1;
         end else begin
            q       <= pol_bit;
            pulse_q <= 1'b0;
         end
      end else if (pulse_q) begin
         q       <= 1'b0;
         pulse_q <= 1'b0;
      end
   end

   assign cpu_irq = q;
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
   parameter int IRQ_W     = 8,
   parameter int IRQ_BASE  = 32,
   parameter int NUM_LINES = 32,
   parameter int SLOT_LO   = 8,
   parameter int SLOT_HI   = 12,
   localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_valid,
   input  logic [7:0]           devfn,
   input  logic [1:0]           pin,
   input  logic [NUM_LINES-1:0] edge_cfg,
   input  logic [NUM_LINES-1:0] pol_cfg,
   output logic [IRQ_W-1:0]     irq_num,
   output logic                 cpu_irq
);
   initial begin
      assert (IRQ_BASE + 6 + (SLOT_HI - SLOT_LO) + 3 < (1 << IRQ_W))
         else $error("irq number width too small");
      assert (SLOT_HI >= SLOT_LO && SLOT_HI < 32)
         else $error("bad expansion slot range");
      assert (IRQ_BASE >= 4)
         else $error("base must clear pass-through numbers");
   end

   logic              hit;
   logic [LINE_W-1:0] line;
   logic              pulse_q;

   pirq_slot_map #(
      .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE), .NUM_LINES(NUM_LINES),
      .SLOT_LO(SLOT_LO), .SLOT_HI(SLOT_HI)
   ) u_map (
      .slot(devfn[7:3]), .pin(pin),
      .irq_num(irq_num), .hit(hit), .line(line)
   );

   pirq_line_drive #(.NUM_LINES(NUM_LINES)) u_drv (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
      .hit(hit), .line(line),
      .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
      .cpu_irq(cpu_irq), .pulse_q(pulse_q)
   );
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
   parameter int IRQ_W     = 8,
   parameter int IRQ_BASE  = 32,
   parameter int NUM_LINES = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ev_valid,
   input logic [7:0]           devfn,
   input logic [1:0]           pin,
   input logic [NUM_LINES-1:0] edge_cfg,
   input logic [NUM_LINES-1:0] pol_cfg,
   input logic [IRQ_W-1:0]     irq_num,
   input logic                 cpu_irq,
   input logic                 pulse_q
);
   logic [4:0] slot;
   logic       routed;
   int         idx;
   assign slot   = devfn[7:3];
   assign idx    = int'(irq_num) - IRQ_BASE;
   assign routed = ev_valid && idx >= 0 && idx < NUM_LINES;

   logic ebit, pbit;
   assign ebit = routed ? edge_cfg[idx] : 1'b0;
   assign pbit = routed ? pol_cfg[idx]  : 1'b0;

   a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !cpu_irq);

   a_r4_fixed_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == 5'd6) |-> (int'(irq_num) == IRQ_BASE + 4));

   a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (slot < 5'd5 || slot > 5'd12) |-> (irq_num == IRQ_W'(pin)));

   a_r7_pulse_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (routed && ebit) |=> cpu_irq);

   a_r7_pulse_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && !routed) |=> !cpu_irq);

   a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
      (routed && !ebit) |=> (cpu_irq == $past(pbit)));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!routed && !pulse_q) |=> $stable(cpu_irq));
endmodule

bind pci_irq_router pci_irq_router_chk #(
   .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE), .NUM_LINES(NUM_LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .devfn(devfn), .pin(pin),
   .edge_cfg(edge_cfg), .pol_cfg(pol_cfg), .irq_num(irq_num),
   .cpu_irq(cpu_irq), .pulse_q(u_drv.pulse_q)
);

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [7:0]  devfn = '0;
   logic [1:0]  pin = '0;
   logic [31:0] edge_cfg = '0;
   logic [31:0] pol_cfg = '0;
   logic [7:0]  irq_num;
   logic        cpu_irq;

   int total = 0;
   int bad = 0;
   bit exp_q = 1'b0;
   bit exp_p = 1'b0;

   always #5 clk = ~clk;

   pci_irq_router uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .devfn(devfn), .pin(pin),
      .edge_cfg(edge_cfg), .pol_cfg(pol_cfg), .irq_num(irq_num), .cpu_irq(cpu_irq)
   );

   function automatic int exp_map(int s, int p);
      if (s == 5) return 32 + p;
      if (s == 6) return 36;
      if (s == 7) return 37;
      if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
      return p;
   endfunction

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive one cycle at negedge, check routing, update model, check the line after the edge.
   task automatic step(bit v, int s, int f, int p, string tag);
      int m;
      ev_valid = v;
      devfn    = {5'(s), 3'(f)};
      pin      = 2'(p);
      #1;
      m = exp_map(s, p);
      check("R3/R4/R5/R6 map", int'(irq_num), m);
      if (v && m >= 32 && m < 64) begin
         if (edge_cfg[m-32]) begin exp_q = 1'b1; exp_p = 1'b1; end
         else begin exp_q = pol_cfg[m-32]; exp_p = 1'b0; end
      end else if (exp_p) begin
         exp_q = 1'b0; exp_p = 1'b0;
      end
      @(negedge clk);
      check(tag, int'(cpu_irq), int'(exp_q));
   endtask

   initial begin
      #1_500_000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset", int'(cpu_irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", int'(cpu_irq), 0);

      // R3, R4, R5 directed mapping
      step(0, 5, 0, 3, "R3 idle");
      step(0, 6, 0, 2, "R4 idle");
      step(0, 7, 1, 0, "R4 idle");
      step(0, 8, 0, 0, "R5 idle");
      step(0, 12, 0, 3, "R5 idle");
      check("R5 slot12 pin3", int'(irq_num), 45);

      // R8 level high then hold
      edge_cfg = '0; pol_cfg = 32'h0000_0010;
      step(1, 6, 0, 1, "R8 level high");
      step(0, 6, 0, 1, "R8 hold");
      // R6 unrouted slot leaves line alone
      step(1, 3, 0, 2, "R6 unrouted no effect");
      step(1, 13, 0, 1, "R6 unrouted no effect");
      // R2 function bits ignored
      step(1, 6, 7, 3, "R2 func bits");
      // R9 pulse after level high ends low
      edge_cfg = 32'h0000_0020;
      step(1, 7, 0, 0, "R9 pulse rises");
      step(0, 7, 0, 0, "R9 pulse ends low");
      // R7 back-to-back pulses
      step(1, 7, 0, 0, "R7 pulse 1");
      step(1, 7, 0, 0, "R7 pulse 2");
      step(0, 7, 0, 0, "R7 fall");
      // R9 level report overrides fall
      step(1, 7, 0, 0, "R7 pulse");
      step(1, 6, 0, 0, "R9 level overrides fall");
      step(0, 6, 0, 0, "R8 hold");

      // random
      for (int i = 0; i < 3000; i++) begin
         int s;
         if (i % 50 == 0) begin
            edge_cfg = $urandom;
            pol_cfg  = $urandom;
         end
         s = ($urandom % 4 == 0) ? int'($urandom % 32) : 5 + int'($urandom % 8);
         step(($urandom % 3) != 0, s, int'($urandom % 8), int'($urandom % 4),
              "R7/R8 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule